// File: doc/BRIEF.md
# Device Slot Allocation Tracker

This block keeps the occupancy map of device slots on one configuration bus. Each slot has one bit, set while a device holds that slot. Three requests change the map: allocate, claim and release. Allocate takes the lowest free slot. Claim takes a slot number the requester chooses. Release frees a numbered slot. Each request is a single-cycle strobe.

Every accepted request produces a one-cycle response. The response carries a valid flag, the slot number it concerns and a two-bit error code. The occupancy vector is exported all the time, so that enumeration and decode logic can see which devices are present. At reset, slot 0 is already taken by the host bridge.

Slot inputs are one bit wider than a slot index needs. Numbers beyond the map can therefore be presented, and the block rejects them.

Top module: `slot_alloc_tracker`

## Requirements
- R1: The map holds 32 slots. Bit i of `occupancy` is 1 exactly when slot i is taken.
- R2: After reset, `occupancy` equals 0x00000001 (slot 0 held by the host bridge) and `rsp_valid` is 0.
- R3: Allocate picks the lowest-numbered free slot, sets its bit and responds with that number and error code 0 (success).
- R4: Allocate with no free slot responds with error code 1 (nothing free) and slot number 0, and the map does not change.
- R5: Claim of a slot number from 32 to 63 responds with error code 2 (invalid slot), echoes the number, and the map does not change.
- R6: Claim of an in-range slot that is taken responds with error code 3 (in use) and leaves the map unchanged. Claim of a free in-range slot sets its bit and responds with code 0.
- R7: Release of an in-range slot clears its bit and responds with code 0, including when the slot was already free.
- R8: Release of a slot number from 32 to 63 responds with error code 2 and leaves the map unchanged.
- R9: Only one request is served per cycle. Allocate wins over claim, and claim wins over release. A request that loses has no effect on the map and gets no response.
- R10: The response appears in the cycle after the request, together with the updated `occupancy`. A cycle with no request gives `rsp_valid` 0 in the next cycle and leaves the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Allocate the lowest free slot |
| claim_req | input | 1 | Claim the slot given on claim_slot |
| claim_slot | input | 6 | Slot number for claim |
| release_req | input | 1 | Free the slot given on release_slot |
| release_slot | input | 6 | Slot number for release |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_slot | output | 6 | Slot the response concerns |
| rsp_err | output | 2 | 0 ok, 1 nothing free, 2 invalid slot, 3 in use |
| occupancy | output | 32 | Current map, bit i for slot i |

## Verification
The bench builds the block with its default parameters: 32 slots and 6-bit slot inputs. With these values the invalid numbers 32 to 63 can be driven on both claim and release. The map can also be filled completely with a short run of allocations, so the nothing-free response and the wrap back to a freed high slot can be reached. A behavioural model in the bench predicts the response and the whole map in every cycle. This covers simultaneous strobes, repeated release of a free slot, and idle cycles between requests.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;

    typedef enum logic [1:0] {
        ERR_OK    = 2'd0,
        ERR_FULL  = 2'd1,
        ERR_RANGE = 2'd2,
        ERR_BUSY  = 2'd3
    } slot_err_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ALLOC = 2'd1,
        OP_CLAIM = 2'd2,
        OP_FREE  = 2'd3
    } slot_op_e;

endpackage

// File: rtl/slot_req_arbiter.sv
module slot_req_arbiter
    import slot_trk_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              alloc_req,
    input  logic              claim_req,
    input  logic [SLOT_W-1:0] claim_slot,
    input  logic              release_req,
    input  logic [SLOT_W-1:0] release_slot,
    output slot_op_e          op,
    output logic [SLOT_W-1:0] op_slot
);

    // Fixed priority: allocate, then claim, then release.
    always_comb begin
        op      = OP_NONE;
        op_slot = '0;
        if (alloc_req) begin
            op = OP_ALLOC;
        end else if (claim_req) begin
            op      = OP_CLAIM;
            op_slot = claim_slot;
        end else if (release_req) begin
            op      = OP_FREE;
            op_slot = release_slot;
        end
    end

endmodule

// File: rtl/slot_first_free.sv
module slot_first_free #(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] occ,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    // free_seen[i] is set when some slot below i is free.
    logic [NUM_SLOTS:0]   free_seen;
    logic [NUM_SLOTS-1:0] first_hot;

    assign free_seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_chain
            assign first_hot[gi]   = ~occ[gi] & ~free_seen[gi];
            assign free_seen[gi+1] = free_seen[gi] | ~occ[gi];
        end
    endgenerate

    assign found = free_seen[NUM_SLOTS];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (first_hot[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/slot_map_core.sv
module slot_map_core
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 6,
    parameter int HOST_SLOT = 0,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_op_e             op,
    input  logic [SLOT_W-1:0]    op_slot,
    input  logic                 free_found,
    input  logic [IDX_W-1:0]     free_idx,
    output logic [NUM_SLOTS-1:0] occ,
    output logic                 rsp_valid,
    output logic [SLOT_W-1:0]    rsp_slot,
    output slot_err_e            rsp_err
);

    localparam logic [SLOT_W:0]    SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);
    localparam logic [NUM_SLOTS-1:0] RESET_MAP = NUM_SLOTS'(1) << HOST_SLOT;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] map;
        logic                 vld;
        logic [SLOT_W-1:0]    slot;
        slot_err_e            err;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       in_range;
    logic [IDX_W-1:0] sel;

    assign in_range = {1'b0, op_slot} < SLOT_LIMIT;
    assign sel      = op_slot[IDX_W-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.vld  = (op != OP_NONE);
        st_d.slot = op_slot;
        st_d.err  = ERR_OK;
        case (op)
            OP_ALLOC: begin
                if (free_found) begin
                    st_d.map[free_idx] = 1'b1;
                    st_d.slot          = SLOT_W'(free_idx);
                end else begin
                    st_d.err  = ERR_FULL;
                    st_d.slot = '0;
                end
            end
            OP_CLAIM: begin
                if (!in_range) begin
                    st_d.err = ERR_RANGE;
                end else if (st_q.map[sel]) begin
                    st_d.err = ERR_BUSY;
                end else begin
                    st_d.map[sel] = 1'b1;
                end
            end
            OP_FREE: begin
                if (!in_range) begin
                    st_d.err = ERR_RANGE;
                end else begin
                    st_d.map[sel] = 1'b0;
                end
            end
            default: begin
                st_d.slot = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.map  <= RESET_MAP;
            st_q.vld  <= 1'b0;
            st_q.slot <= '0;
            st_q.err  <= ERR_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ       = st_q.map;
    assign rsp_valid = st_q.vld;
    assign rsp_slot  = st_q.slot;
    assign rsp_err   = st_q.err;

    // R3: a successful allocate flips exactly one bit, from free to taken
    a_r3_alloc_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ALLOC) |=> (rsp_err == ERR_FULL) ||
            (($countones(occ ^ $past(occ)) == 1) && occ[rsp_slot[IDX_W-1:0]]));

    // R4: nothing free leaves the map as it was
    a_r4_full_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == ERR_FULL) |-> $stable(occ));

    // R5, R8: out-of-range numbers are rejected without touching the map
    a_r5_r8_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_CLAIM || op == OP_FREE) && !in_range) |=>
            (rsp_err == ERR_RANGE) && $stable(occ));

    // R6: claim of a taken slot leaves the map as it was
    a_r6_busy_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == ERR_BUSY) |-> $stable(occ));

    // R7: in-range release always succeeds and the bit ends clear
    a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FREE && in_range) |=>
            (rsp_err == ERR_OK) && !occ[$past(sel)]);

    // R10: idle cycle gives no response and no map change
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> !rsp_valid && $stable(occ));

endmodule

// File: rtl/slot_alloc_tracker.sv
module slot_alloc_tracker
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 6,
    parameter int HOST_SLOT = 0,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic                 claim_req,
    input  logic [SLOT_W-1:0]    claim_slot,
    input  logic                 release_req,
    input  logic [SLOT_W-1:0]    release_slot,
    output logic                 rsp_valid,
    output logic [SLOT_W-1:0]    rsp_slot,
    output logic [1:0]           rsp_err,
    output logic [NUM_SLOTS-1:0] occupancy
);

    slot_op_e          op;
    logic [SLOT_W-1:0] op_slot;
    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    slot_err_e         err_e;

    slot_req_arbiter #(.SLOT_W(SLOT_W)) u_arb (
        .alloc_req    (alloc_req),
        .claim_req    (claim_req),
        .claim_slot   (claim_slot),
        .release_req  (release_req),
        .release_slot (release_slot),
        .op           (op),
        .op_slot      (op_slot)
    );

    slot_first_free #(.NUM_SLOTS(NUM_SLOTS)) u_ff (
        .occ   (occupancy),
        .found (free_found),
        .idx   (free_idx)
    );

    slot_map_core #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .HOST_SLOT (HOST_SLOT)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .op_slot    (op_slot),
        .free_found (free_found),
        .free_idx   (free_idx),
        .occ        (occupancy),
        .rsp_valid  (rsp_valid),
        .rsp_slot   (rsp_slot),
        .rsp_err    (err_e)
    );

    assign rsp_err = err_e;

    // R9: with allocate present, claim and release outcomes never appear
    a_r9_alloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> rsp_valid && (rsp_err == 2'd0 || rsp_err == 2'd1));

    // R10: any strobe yields a response in the next cycle
    a_r10_response_next: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req || claim_req || release_req) |=> rsp_valid);

endmodule

// File: tb/tb_slot_alloc_tracker.sv
`timescale 1ns/1ps
module tb_slot_alloc_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic        claim_req = 1'b0;
    logic [5:0]  claim_slot = '0;
    logic        release_req = 1'b0;
    logic [5:0]  release_slot = '0;
    logic        rsp_valid;
    logic [5:0]  rsp_slot;
    logic [1:0]  rsp_err;
    logic [31:0] occupancy;

    always #2.5 clk = ~clk;

    slot_alloc_tracker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_req    (alloc_req),
        .claim_req    (claim_req),
        .claim_slot   (claim_slot),
        .release_req  (release_req),
        .release_slot (release_slot),
        .rsp_valid    (rsp_valid),
        .rsp_slot     (rsp_slot),
        .rsp_err      (rsp_err),
        .occupancy    (occupancy)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    // reference model
    bit [31:0] m_occ = 32'h1;
    bit        e_vld = 0;
    int        e_slot = 0;
    int        e_err = 0;
    string     e_tag = "R2";

    task automatic chk(string tag, string what, longint act, longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic check_outputs();
        chk(e_tag, "rsp_valid", rsp_valid, e_vld);
        chk(e_tag == "R2" ? "R2" : "R1", "occupancy", occupancy, m_occ);
        if (e_vld) begin
            chk(e_tag, "rsp_slot", rsp_slot, e_slot);
            chk(e_tag, "rsp_err", rsp_err, e_err);
        end
    endtask

    task automatic model(bit a, bit c, int cs, bit r, int rs);
        int hit;
        e_vld = a | c | r;
        e_err = 0;
        e_slot = 0;
        e_tag = "R10";
        if (a) begin
            hit = -1;
            for (int i = 31; i >= 0; i--) if (!m_occ[i]) hit = i;
            if (hit < 0) begin
                e_err = 1; e_slot = 0; e_tag = "R4";
            end else begin
                m_occ[hit] = 1'b1; e_slot = hit; e_tag = "R3";
            end
            if (c || r) e_tag = "R9";
        end else if (c) begin
            e_slot = cs;
            if (cs >= 32) begin
                e_err = 2; e_tag = "R5";
            end else if (m_occ[cs]) begin
                e_err = 3; e_tag = "R6";
            end else begin
                m_occ[cs] = 1'b1; e_tag = "R6";
            end
            if (r) e_tag = "R9";
        end else if (r) begin
            e_slot = rs;
            if (rs >= 32) begin
                e_err = 2; e_tag = "R8";
            end else begin
                m_occ[rs] = 1'b0; e_tag = "R7";
            end
        end
    endtask

    task automatic step(bit a, bit c, int cs, bit r, int rs);
        @(negedge clk);
        check_outputs();
        alloc_req    = a;
        claim_req    = c;
        claim_slot   = 6'(cs);
        release_req  = r;
        release_slot = 6'(rs);
        model(a, c, cs, r, rs);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: state while in reset
        chk("R2", "occupancy in reset", occupancy, 32'h1);
        chk("R2", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);                       // R10 idle, R2 state after reset
        for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0);   // R3 slots 1..5
        step(0, 0, 0, 1, 3);                       // R7
        step(1, 0, 0, 0, 0);                       // R3 reuses 3
        step(0, 0, 0, 1, 3);                       // R7
        step(0, 0, 0, 1, 3);                       // R7 already free
        step(0, 1, 40, 0, 0);                      // R5
        step(0, 1, 32, 0, 0);                      // R5
        step(0, 1, 63, 0, 0);                      // R5
        step(0, 1, 2, 0, 0);                       // R6 busy
        step(0, 1, 0, 0, 0);                       // R6 host slot busy
        step(0, 1, 10, 0, 0);                      // R6 success
        step(0, 1, 31, 0, 0);                      // R6 top slot
        step(0, 0, 0, 1, 33);                      // R8
        step(0, 0, 0, 1, 63);                      // R8
        step(1, 1, 12, 1, 2);                      // R9 allocate wins
        step(0, 1, 12, 1, 2);                      // R9 claim wins
        step(0, 0, 0, 0, 0);                       // R10
        step(0, 0, 0, 1, 31);                      // R7
        for (int k = 0; k < 32; k++) step(1, 0, 0, 0, 0);  // R3 fill, R4 when full
        step(0, 1, 7, 0, 0);                       // R6 busy while full
        step(0, 0, 0, 1, 31);                      // R7
        step(1, 0, 0, 0, 0);                       // R3 takes 31
        step(1, 0, 0, 0, 0);                       // R4
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule